// File: doc/BRIEF.md
# Offset-Coded Reference and Feedback Divider Pair

This block contains the two programmable integer dividers that sit in front of a phase comparator. One lane divides the reference clock by R and the other divides the oscillator clock by V. Each lane produces a pulse one clock wide, once every N cycles of its own clock. The comparator then lines up the two pulse trains.

Each divisor is given as a parallel code word that carries an offset. For the feedback lane, V is the code plus eight. For the reference lane, a mode input chooses between two encodings. In the first, R is a seven-bit code plus two. In the second, R is the low six bits of the code taken as is. One feedback ratio inside the legal range is forbidden, and the block raises a flag whenever it is selected. A code change is picked up only at the end of the count in progress. Reset and an active-low power-down input both clear the two counters.

Top module: `offset_div_pair`

## Requirements
- R1: The feedback lane divides by V = fbCode + 8. fbCode is 9 bits wide, so V runs from 8 to 519.
- R2: cfgInvalid is 1 exactly when fbCode equals 3 (V = 11) and 0 for every other feedback code, independent of the clocks. The feedback lane still divides by 11 while the flag is raised.
- R3: With directMode = 0, the reference lane divides by R = refCode + 2. refCode is 7 bits, so R runs from 2 to 129.
- R4: With directMode = 1, the reference lane divides by R = refCode[5:0], and refCode[6] has no effect on the output.
- R5: With directMode = 1, a value of 0 in refCode[5:0] selects R = 64. A value of 1 selects R = 1, and the output then stays high on every cycle.
- R6: While a divisor is held constant, each output is high for exactly one cycle of its own clock in every N cycles, with no missing and no extra pulses.
- R7: A divisor is sampled on the clock edge that ends a count. The count that follows uses the code present on that edge, and a code that changes and changes back between two such edges has no effect.
- R8: While rstN is low, both outputs are 0. After release, the first pulse of a lane appears after its (N+1)th rising edge, where N is decoded from the code present on the first of those edges.
- R9: A rising edge on which pwrDnN is low forces that lane's output to 0 and clears its count. After pwrDnN returns high, each lane restarts exactly as it does after reset (R8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference input clock |
| fbClk | input | 1 | Oscillator (feedback) clock |
| rstN | input | 1 | Asynchronous active-low reset for both lanes |
| pwrDnN | input | 1 | Active-low power-down, sampled in each lane's clock domain |
| directMode | input | 1 | 0: reference code is offset by 2; 1: 6-bit direct code |
| refCode | input | 7 | Reference divisor code |
| fbCode | input | 9 | Feedback divisor code (V - 8) |
| refPulse | output | 1 | Reference pulse train, refClk domain |
| fbPulse | output | 1 | Feedback pulse train, fbClk domain |
| cfgInvalid | output | 1 | High when the forbidden feedback ratio is selected |

## Verification
The hardest case to reach is a code that changes partway through a count, while the other clock keeps running at an unrelated rate. The check has to show that the new value is applied only at the wrap edge, and is neither lost nor applied early. The stimulus changes each lane's code at random points on that lane's own clock, so changes fall at every position inside a count, including the wrap edge itself. The bench model reads the code on each rising edge and predicts the next pulse from the code present on the wrap edge. Directed phases add the extreme ratios (8, 519, 1, 2, 64, 129), the forbidden ratio, toggling of the ignored high bit in direct mode, and a power-down and a reset in the middle of a run.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
  // Control-to-datapath strobes for one divider lane
  typedef struct packed {
    logic clr;   // hold count at zero and reload divisor
    logic load;  // end of count: restart and reload divisor
  } divStrobe_t;

  localparam int unsigned LANE_REF = 0;
  localparam int unsigned LANE_FB  = 1;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/odiv_decode.sv
module odiv_decode #(
  parameter int unsigned FB_CODE_W  = 9,
  parameter int unsigned REF_CODE_W = 7,
  parameter int unsigned DIRECT_W   = 6,
  parameter int unsigned FB_OFFSET  = 8,
  parameter int unsigned REF_OFFSET = 2,
  parameter int unsigned FB_FORBID  = 3,
  parameter int unsigned DIV_W      = 10
) (
  input  logic [FB_CODE_W-1:0]  fbCode,
  input  logic [REF_CODE_W-1:0] refCode,
  input  logic                  directMode,
  output logic [DIV_W-1:0]      fbDiv,
  output logic [DIV_W-1:0]      refDiv,
  output logic                  cfgInvalid
);
  localparam logic [DIV_W-1:0] DIRECT_ZERO_DIV = DIV_W'(1) << DIRECT_W;

  logic [DIRECT_W-1:0] directCode;

  assign directCode = refCode[DIRECT_W-1:0];

  always_comb begin
    fbDiv = DIV_W'(fbCode) + DIV_W'(FB_OFFSET);
    if (directMode) begin
      refDiv = (directCode == '0) ? DIRECT_ZERO_DIV : DIV_W'(directCode);
    end else begin
      refDiv = DIV_W'(refCode) + DIV_W'(REF_OFFSET);
    end
    cfgInvalid = (fbCode == FB_CODE_W'(FB_FORBID));
  end
endmodule

// File: rtl/odiv_seq.sv
module odiv_seq
  import odiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       terminal,
  output divStrobe_t strb
);
  logic armed;
  logic run;

  // One settling edge after reset or power-down exit loads the divisor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else begin
      armed <= pwrDnN;
    end
  end

  assign run = armed & pwrDnN;

  always_comb begin
    strb.clr  = ~run;
    strb.load = run & terminal;
  end
endmodule

// File: rtl/odiv_count.sv
module odiv_count
  import odiv_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strb,
  input  logic [DIV_W-1:0] nextDiv,
  output logic             terminal,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curDiv;

  assign terminal = (cnt == DIV_W'(curDiv - DIV_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      curDiv <= DIV_W'(1);
      pulse  <= 1'b0;
    end else if (strb.clr) begin
      cnt    <= '0;
      curDiv <= nextDiv;
      pulse  <= 1'b0;
    end else if (strb.load) begin
      cnt    <= '0;
      curDiv <= nextDiv;
      pulse  <= 1'b1;
    end else begin
      cnt    <= cnt + DIV_W'(1);
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/offset_div_pair.sv
module offset_div_pair
  import odiv_pkg::*;
#(
  parameter int unsigned FB_CODE_W  = 9,
  parameter int unsigned REF_CODE_W = 7,
  parameter int unsigned DIRECT_W   = 6,
  parameter int unsigned FB_OFFSET  = 8,
  parameter int unsigned REF_OFFSET = 2,
  parameter int unsigned FB_FORBID  = 3
) (
  input  logic                  refClk,
  input  logic                  fbClk,
  input  logic                  rstN,
  input  logic                  pwrDnN,
  input  logic                  directMode,
  input  logic [REF_CODE_W-1:0] refCode,
  input  logic [FB_CODE_W-1:0]  fbCode,
  output logic                  refPulse,
  output logic                  fbPulse,
  output logic                  cfgInvalid
);
  localparam int unsigned FB_MAX  = (1 << FB_CODE_W) - 1 + FB_OFFSET;
  localparam int unsigned REF_MAX = (1 << REF_CODE_W) - 1 + REF_OFFSET;
  localparam int unsigned DIR_MAX = 1 << DIRECT_W;
  localparam int unsigned ANY_MAX = (FB_MAX > REF_MAX)
                                    ? ((FB_MAX > DIR_MAX) ? FB_MAX : DIR_MAX)
                                    : ((REF_MAX > DIR_MAX) ? REF_MAX : DIR_MAX);
  localparam int unsigned DIV_W   = $clog2(ANY_MAX + 1);

  logic [DIV_W-1:0]     laneDiv   [NUM_LANES];
  logic [NUM_LANES-1:0] laneClk;
  logic [NUM_LANES-1:0] laneTerm;
  logic [NUM_LANES-1:0] lanePulse;
  divStrobe_t           laneStrb  [NUM_LANES];

  odiv_decode #(
    .FB_CODE_W (FB_CODE_W),
    .REF_CODE_W(REF_CODE_W),
    .DIRECT_W  (DIRECT_W),
    .FB_OFFSET (FB_OFFSET),
    .REF_OFFSET(REF_OFFSET),
    .FB_FORBID (FB_FORBID),
    .DIV_W     (DIV_W)
  ) i_decode (
    .fbCode    (fbCode),
    .refCode   (refCode),
    .directMode(directMode),
    .fbDiv     (laneDiv[LANE_FB]),
    .refDiv    (laneDiv[LANE_REF]),
    .cfgInvalid(cfgInvalid)
  );

  assign laneClk[LANE_REF] = refClk;
  assign laneClk[LANE_FB]  = fbClk;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    odiv_seq i_seq (
      .clk     (laneClk[g]),
      .rstN    (rstN),
      .pwrDnN  (pwrDnN),
      .terminal(laneTerm[g]),
      .strb    (laneStrb[g])
    );

    odiv_count #(.DIV_W(DIV_W)) i_count (
      .clk     (laneClk[g]),
      .rstN    (rstN),
      .strb    (laneStrb[g]),
      .nextDiv (laneDiv[g]),
      .terminal(laneTerm[g]),
      .pulse   (lanePulse[g])
    );
  end

  assign refPulse = lanePulse[LANE_REF];
  assign fbPulse  = lanePulse[LANE_FB];
endmodule

// File: rtl/odiv_checker.sv
module odiv_checker #(
  parameter int unsigned FB_CODE_W  = 9,
  parameter int unsigned REF_CODE_W = 7,
  parameter int unsigned FB_FORBID  = 3
) (
  input logic                  refClk,
  input logic                  fbClk,
  input logic                  rstN,
  input logic                  pwrDnN,
  input logic                  directMode,
  input logic [REF_CODE_W-1:0] refCode,
  input logic [FB_CODE_W-1:0]  fbCode,
  input logic                  refPulse,
  input logic                  fbPulse,
  input logic                  cfgInvalid
);
  // R2: forbidden ratio raises the flag
  p_flag_set_r2: assert property (@(posedge fbClk) disable iff (!rstN)
    (fbCode == FB_CODE_W'(FB_FORBID)) |-> cfgInvalid);

  // R2: any other feedback code keeps the flag low
  p_flag_clear_r2: assert property (@(posedge fbClk) disable iff (!rstN)
    (fbCode != FB_CODE_W'(FB_FORBID)) |-> !cfgInvalid);

  // R1 / R6: feedback ratio is at least 8, so a pulse is followed by low cycles
  p_fb_gap_r6: assert property (@(posedge fbClk) disable iff (!rstN)
    fbPulse |=> !fbPulse ##1 !fbPulse ##1 !fbPulse);

  // R9: power-down silences the feedback lane
  p_pd_fb_r9: assert property (@(posedge fbClk) disable iff (!rstN)
    !pwrDnN |=> !fbPulse);

  // R9: power-down silences the reference lane
  p_pd_ref_r9: assert property (@(posedge refClk) disable iff (!rstN)
    !pwrDnN |=> !refPulse);

  // R9: the first edge after power-down exit only reloads
  p_pd_exit_r9: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(pwrDnN) |=> !refPulse);

  // R8: reset holds both outputs low
  always_comb begin
    if (!rstN) begin
      a_reset_quiet_r8: assert (!refPulse && !fbPulse);
    end
  end
endmodule

bind offset_div_pair odiv_checker #(
  .FB_CODE_W (FB_CODE_W),
  .REF_CODE_W(REF_CODE_W),
  .FB_FORBID (FB_FORBID)
) i_odiv_checker (
  .refClk    (refClk),
  .fbClk     (fbClk),
  .rstN      (rstN),
  .pwrDnN    (pwrDnN),
  .directMode(directMode),
  .refCode   (refCode),
  .fbCode    (fbCode),
  .refPulse  (refPulse),
  .fbPulse   (fbPulse),
  .cfgInvalid(cfgInvalid)
);

// File: tb/test_offset_div_pair.sv
`timescale 1ns/100ps
module test_offset_div_pair;
  logic       refClk = 1'b0;
  logic       fbClk  = 1'b0;
  logic       rstN   = 1'b0;
  logic       pwrDnN = 1'b1;
  logic       directMode = 1'b0;
  logic [6:0] refCode = 7'd0;
  logic [8:0] fbCode  = 9'd0;
  logic       refPulse, fbPulse, cfgInvalid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 refClk = ~refClk;   // 200 MHz
  always #3.1 fbClk  = ~fbClk;    // unrelated oscillator rate

  offset_div_pair i_offset_div_pair (
    .refClk(refClk), .fbClk(fbClk), .rstN(rstN), .pwrDnN(pwrDnN),
    .directMode(directMode), .refCode(refCode), .fbCode(fbCode),
    .refPulse(refPulse), .fbPulse(fbPulse), .cfgInvalid(cfgInvalid)
  );

  function automatic int expFbDiv(input logic [8:0] c);
    return int'(c) + 8;
  endfunction

  function automatic int expRefDiv(input logic m, input logic [6:0] c);
    if (!m) return int'(c) + 2;
    if (c[5:0] == 6'd0) return 64;
    return int'(c[5:0]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Feedback lane model: R1 R6 R7 R8 R9
  longint fbIdx = 0, fbNext = 0;
  bit     fbArmed = 1'b0, fbExp = 1'b0;
  always @(posedge fbClk) begin
    fbIdx++;
    if (!rstN || !pwrDnN) begin
      fbArmed = 1'b0; fbExp = 1'b0;
    end else if (!fbArmed) begin
      fbArmed = 1'b1; fbExp = 1'b0; fbNext = fbIdx + expFbDiv(fbCode);
    end else if (fbIdx == fbNext) begin
      fbExp = 1'b1; fbNext = fbIdx + expFbDiv(fbCode);
    end else begin
      fbExp = 1'b0;
    end
    #1;
    check(fbPulse == (fbExp & rstN), "R1 R6 R7 R8 R9 fbPulse", int'(fbPulse), int'(fbExp & rstN));
  end

  // Reference lane model: R3 R4 R5 R6 R7 R8 R9
  longint refIdx = 0, refNext = 0;
  bit     refArmed = 1'b0, refExp = 1'b0;
  always @(posedge refClk) begin
    refIdx++;
    if (!rstN || !pwrDnN) begin
      refArmed = 1'b0; refExp = 1'b0;
    end else if (!refArmed) begin
      refArmed = 1'b1; refExp = 1'b0; refNext = refIdx + expRefDiv(directMode, refCode);
    end else if (refIdx == refNext) begin
      refExp = 1'b1; refNext = refIdx + expRefDiv(directMode, refCode);
    end else begin
      refExp = 1'b0;
    end
    #1;
    check(refPulse == (refExp & rstN), "R3 R4 R5 R6 R7 R8 R9 refPulse", int'(refPulse), int'(refExp & rstN));
  end

  // Feedback code driver, on the feedback clock
  initial begin : fb_driver
    logic [8:0] dirList [5];
    int unsigned seedDummy;
    dirList[0] = 9'd0; dirList[1] = 9'd3; dirList[2] = 9'd511;
    dirList[3] = 9'd1; dirList[4] = 9'd200;
    seedDummy = $urandom(32'h0DD5EED);
    wait (rstN === 1'b1);
    for (int i = 0; !done; i++) begin
      logic [8:0] c;
      int hold;
      c = (i < 5) ? dirList[i] : 9'($urandom_range(0, 120));
      if (i >= 5 && ($urandom_range(0, 5) == 0)) c = 9'd3;
      @(negedge fbClk);
      fbCode = c;
      #0.5;
      check(cfgInvalid == (c == 9'd3), "R2 cfgInvalid", int'(cfgInvalid), int'(c == 9'd3));
      hold = 3 * expFbDiv(c) + int'($urandom_range(0, 23));
      for (int k = 0; k < hold && !done; k++) @(negedge fbClk);
    end
  end

  task automatic refPhase(input logic m, input logic [6:0] c, input int cycles);
    @(negedge refClk);
    directMode = m;
    refCode    = c;
    repeat (cycles) @(negedge refClk);
  endtask

  initial begin : main
    rstN = 1'b0;
    repeat (4) @(negedge refClk);
    check(!refPulse && !fbPulse, "R8 reset outputs", int'({refPulse, fbPulse}), 0);
    rstN = 1'b1;
    refPhase(1'b0, 7'd0,   200);   // R3 R = 2
    refPhase(1'b0, 7'd127, 450);   // R3 R = 129
    refPhase(1'b1, 7'd0,   250);   // R5 R = 64
    refPhase(1'b1, 7'd1,   40);    // R5 R = 1
    refPhase(1'b1, 7'h45,  60);    // R4 bit 6 set, R = 5
    refPhase(1'b1, 7'h05,  60);    // R4 bit 6 cleared, same R
    refPhase(1'b1, 7'h45,  60);
    // R9 power-down mid-run
    @(negedge refClk); pwrDnN = 1'b0;
    repeat (30) @(negedge refClk);
    check(!refPulse && !fbPulse, "R9 power-down outputs", int'({refPulse, fbPulse}), 0);
    pwrDnN = 1'b1;
    refPhase(1'b0, 7'd9, 100);
    // R7 random code changes at arbitrary points of the count
    for (int i = 0; i < 40; i++) begin
      refPhase(1'($urandom_range(0, 1)), 7'($urandom_range(0, 127)),
               int'($urandom_range(3, 90)));
    end
    // R8 reset mid-run
    @(negedge refClk); rstN = 1'b0;
    repeat (5) @(negedge refClk);
    check(!refPulse && !fbPulse, "R8 mid-run reset outputs", int'({refPulse, fbPulse}), 0);
    rstN = 1'b1;
    refPhase(1'b0, 7'd3, 200);
    refPhase(1'b1, 7'd17, 200);
    repeat (2000) @(negedge refClk);
    done = 1'b1;
    repeat (4) @(negedge refClk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : watchdog
    #900000;
    nFails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule